// File: doc/BRIEF.md
# Half-Bridge On-Time Mirroring Controller

This block drives the two switches of a resonant half-bridge. Each switching cycle opens with a dead time. The upper switch then conducts while a counter measures, in clock steps, how long it takes the external on-time comparator to report that the sensed current has reached the feedback set point. After a second dead time, the lower switch conducts while the same counter runs back down to zero. Both switches therefore get the same conduction time, and the cycle repeats.

When the comparator is already asserted as an upper interval begins, the sensed signal is out of balance and no new measurement can be made. In that case the block repeats the last valid on-time. It returns to measuring as soon as the comparator is released at the start of an upper interval. A counter step is one clock period, which is 10 ns at 100 MHz. The dead time is a per-interval programmable count. A one-cycle marker at the start of every upper interval lets downstream logic count upper pulses.

Top module: `hbm_ctrl`

## Requirements
- R1: Phases follow the fixed order dead time, upper on, dead time, lower on, dead time, and so on. After enable or reset, the first conduction interval is always an upper one.
- R2: In measuring mode the upper interval lasts T clock cycles, where the comparator input is first seen high in the T-th upper cycle (T of 2 or more). From the first cycle after that interval, ton_q reads T.
- R3: Every lower interval lasts exactly as many clock cycles as the upper interval just before it.
- R4: Every dead interval lasts max(dt_cfg, 1) clock cycles, with both drive outputs low. dt_cfg is sampled in the first cycle of the interval, so later changes in that interval have no effect on its length.
- R5: drv_hi and drv_lo are never high in the same cycle.
- R6: If the comparator input is high in the first cycle of an upper interval, that interval lasts ton_q cycles and ton_q does not change.
- R7: If the comparator never trips, the upper interval ends after 4095 cycles (the 12-bit maximum) and ton_q becomes 4095.
- R8: While en is low, both drive outputs are low at once, and ton_q reads 10 from the next clock edge. An active-low reset forces the outputs low and ton_q to 10 immediately. After either, the block restarts from a dead interval.
- R9: hi_start is high for exactly one cycle, the first cycle of each upper interval, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one on-time step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low forces idle and clears the stored on-time |
| cmp_trip | input | 1 | On-time comparator flag: sensed current has crossed the set point |
| dt_cfg | input | 6 | Dead-time length in clock cycles (0 is treated as 1) |
| drv_hi | output | 1 | Upper switch gate drive |
| drv_lo | output | 1 | Lower switch gate drive |
| hi_start | output | 1 | One-cycle marker in the first cycle of each upper interval |
| ton_q | output | 12 | Last valid upper on-time in clock cycles |

## Verification
A corrupted count in the shared counter appears at the ports within one switching cycle: the lower pulse no longer matches the upper pulse it follows, or ton_q disagrees with the cycle in which the comparator was raised. A wrong phase state shows as two conduction intervals of the same kind back to back, a missing dead gap, or overlapping drives, on the very next phase change. A stuck repeat flag or a wrongly sampled dead time shows in the width of the next upper or dead interval. The bench therefore measures every interval width and order at the ports and compares each against what the stimulus implies.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [1:0] {
    PH_GAP_PRE_HI = 2'd0,
    PH_HI_ON      = 2'd1,
    PH_GAP_PRE_LO = 2'd2,
    PH_LO_ON      = 2'd3
  } hbm_phase_e;

endpackage

// File: rtl/hbm_rst_sync.sv
module hbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sh_q <= '0;
        else          sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sh_q <= '0;
        else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/hbm_dead_timer.sv
module hbm_dead_timer #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            active_i,
  input  logic [DT_W-1:0] cfg_i,
  output logic            done_o
);

  localparam int LW = DT_W + 1;

  logic [DT_W-1:0] cnt_q, cnt_d;
  logic [DT_W-1:0] len_q, len_d;
  logic            len_we;
  logic [DT_W-1:0] cfg_eff;
  logic [DT_W-1:0] lim;

  // A zero setting still yields a one-cycle gap.
  always_comb begin
    cfg_eff = (cfg_i == '0) ? DT_W'(1) : cfg_i;
    // The first gap cycle uses the live setting; later cycles use the latched one.
    lim     = (cnt_q == '0) ? cfg_eff : len_q;
    done_o  = active_i && (({1'b0, cnt_q} + LW'(1)) == {1'b0, lim});
  end

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    len_we = 1'b0;
    if (clr_i || !active_i) begin
      cnt_d = '0;
    end else begin
      if (cnt_q == '0) begin
        len_d  = cfg_eff;
        len_we = 1'b1;
      end
      cnt_d = done_o ? '0 : cnt_q + DT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= DT_W'(1);
    else if (len_we) len_q <= len_d;
  end

endmodule

// File: rtl/hbm_ton_counter.sv
module hbm_ton_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_we = clr_i || inc_i || dec_i;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + CNT_W'(1);
    else if (dec_i) cnt_d = cnt_q - CNT_W'(1);
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hbm_seq.sv
module hbm_seq
  import hbm_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int TON_DEF = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             cmp_i,
  input  logic             gap_done_i,
  input  logic [CNT_W-1:0] cnt_i,
  output hbm_phase_e       phase_o,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             cnt_dec_o,
  output logic [CNT_W-1:0] ton_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TON_RST = CNT_W'(TON_DEF);

  hbm_phase_e       phase_q, phase_d;
  logic             reuse_q, reuse_d;
  logic [CNT_W-1:0] ton_q, ton_d;
  logic             ton_we;

  logic             first_hi;
  logic             reuse_now;
  logic [CNT_W-1:0] cnt_plus;
  logic             hi_end;
  logic             lo_end;

  // Interval-end decisions.
  always_comb begin
    first_hi  = (phase_q == PH_HI_ON) && (cnt_i == '0);
    reuse_now = first_hi ? cmp_i : reuse_q;
    cnt_plus  = cnt_i + CNT_ONE;
    hi_end    = 1'b0;
    if (phase_q == PH_HI_ON) begin
      if (reuse_now) hi_end = (cnt_plus == ton_q);
      else           hi_end = (cmp_i && !first_hi) || (cnt_plus == CNT_MAX);
    end
    lo_end = (phase_q == PH_LO_ON) && ((cnt_i == CNT_ONE) || (cnt_i == '0));
  end

  // Next phase.
  always_comb begin
    phase_d = phase_q;
    if (!en_i) begin
      phase_d = PH_GAP_PRE_HI;
    end else begin
      unique case (phase_q)
        PH_GAP_PRE_HI: if (gap_done_i) phase_d = PH_HI_ON;
        PH_HI_ON:      if (hi_end)     phase_d = PH_GAP_PRE_LO;
        PH_GAP_PRE_LO: if (gap_done_i) phase_d = PH_LO_ON;
        PH_LO_ON:      if (lo_end)     phase_d = PH_GAP_PRE_HI;
        default:                       phase_d = PH_GAP_PRE_HI;
      endcase
    end
  end

  // Repeat flag and stored on-time.
  always_comb begin
    reuse_d = (en_i && (phase_q == PH_HI_ON)) ? reuse_now : 1'b0;
    ton_we  = 1'b0;
    ton_d   = ton_q;
    if (!en_i) begin
      ton_we = 1'b1;
      ton_d  = TON_RST;
    end else if (hi_end && !reuse_now) begin
      ton_we = 1'b1;
      ton_d  = cnt_plus;
    end
  end

  // Counter steering.
  always_comb begin
    cnt_clr_o = !en_i || (phase_q == PH_GAP_PRE_HI);
    cnt_inc_o = en_i && (phase_q == PH_HI_ON);
    cnt_dec_o = en_i && (phase_q == PH_LO_ON) && (cnt_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_GAP_PRE_HI;
      reuse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      reuse_q <= reuse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ton_q <= TON_RST;
    else if (ton_we) ton_q <= ton_d;
  end

  assign phase_o = phase_q;
  assign ton_o   = ton_q;

endmodule

// File: rtl/hbm_ctrl.sv
module hbm_ctrl
  import hbm_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DT_W      = 6,
  parameter int TON_DEF   = 10,
  parameter int RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cmp_trip,
  input  logic [DT_W-1:0]  dt_cfg,
  output logic             drv_hi,
  output logic             drv_lo,
  output logic             hi_start,
  output logic [CNT_W-1:0] ton_q
);

  logic             rst_n_s;
  hbm_phase_e       phase;
  logic             gap_active;
  logic             gap_done;
  logic             cnt_clr, cnt_inc, cnt_dec;
  logic [CNT_W-1:0] cnt;

  hbm_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign gap_active = en && ((phase == PH_GAP_PRE_HI) || (phase == PH_GAP_PRE_LO));

  hbm_dead_timer #(.DT_W(DT_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (!en),
    .active_i (gap_active),
    .cfg_i    (dt_cfg),
    .done_o   (gap_done)
  );

  hbm_ton_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .dec_i (cnt_dec),
    .cnt_o (cnt)
  );

  hbm_seq #(.CNT_W(CNT_W), .TON_DEF(TON_DEF)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en_i       (en),
    .cmp_i      (cmp_trip),
    .gap_done_i (gap_done),
    .cnt_i      (cnt),
    .phase_o    (phase),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .cnt_dec_o  (cnt_dec),
    .ton_o      (ton_q)
  );

  assign drv_hi   = en && (phase == PH_HI_ON);
  assign drv_lo   = en && (phase == PH_LO_ON);
  assign hi_start = drv_hi && (cnt == '0);

endmodule

// File: rtl/hbm_ctrl_chk.sv
module hbm_ctrl_chk #(
  parameter int CNT_W   = 12,
  parameter int TON_DEF = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             drv_hi,
  input logic             drv_lo,
  input logic             hi_start,
  input logic [CNT_W-1:0] ton_q
);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));

  a_r1_gap_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_lo) |-> !$past(drv_hi));

  a_r1_gap_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> !$past(drv_lo));

  a_r9_marker_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_hi) |-> hi_start);

  a_r9_marker_single: assert property (@(posedge clk) disable iff (!rst_n)
    hi_start |=> !hi_start);

  a_r8_default_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ton_q == CNT_W'(TON_DEF)));

  a_r2_ton_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ton_q >= CNT_W'(2));

  a_r2_ton_hold_in_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hi && $past(drv_hi)) |-> $stable(ton_q));

endmodule

bind hbm_ctrl hbm_ctrl_chk #(.CNT_W(CNT_W), .TON_DEF(TON_DEF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .drv_hi   (drv_hi),
  .drv_lo   (drv_lo),
  .hi_start (hi_start),
  .ton_q    (ton_q)
);

// File: tb/hbm_ctrl_bench.sv
module hbm_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic        cmp_trip;
  logic [5:0]  dt_cfg;
  logic        drv_hi, drv_lo, hi_start;
  logic [11:0] ton_q;

  int n_chk  = 0;
  int n_fail = 0;

  // Stimulus controls, written by the sequence, read by the monitor.
  bit rand_mode = 0;
  bit force_trip = 0;
  bit mid_swap = 0;
  int fixed_t = 8;
  int dt_fixed = 6;

  // Monitor state.
  int prev_ph = 0;
  int run = 0;
  int target = 8;
  int dead_rec = 0;
  int ton_start = 10;
  bit reuse_this = 0;
  bit dead_ok = 0;
  int last_cond = 0;
  int last_hi = 0;
  int hi_done = 0;

  hbm_ctrl u_hbm_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cmp_trip (cmp_trip),
    .dt_cfg   (dt_cfg),
    .drv_hi   (drv_hi),
    .drv_lo   (drv_lo),
    .hi_start (hi_start),
    .ton_q    (ton_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gap_len(input int cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

  function automatic int hi_expect(input bit reuse, input int ton0, input int t);
    if (reuse)  return ton0;
    if (t == 0) return 4095;
    return t;
  endfunction

  function automatic int pick_t();
    return rand_mode ? 2 + int'($urandom % 30) : fixed_t;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Port monitor and comparator model, evaluated away from the active edge.
  always @(negedge clk) begin
    int ph;
    int exp_w;
    if (!rst_n || !en) begin
      prev_ph   = 0;
      run       = 0;
      dead_ok   = 0;
      last_cond = 0;
      cmp_trip  = 1'b0;
      target    = pick_t();
      dt_cfg    = 6'(dt_fixed);
    end else begin
      ph = drv_hi ? 1 : (drv_lo ? 2 : 0);
      if (drv_hi && drv_lo) chk(1'b0, "R5 overlap", 1, 0);
      if (hi_start || (ph == 1 && prev_ph != 1))
        chk(hi_start == (ph == 1 && prev_ph != 1), "R9 start marker",
            int'(hi_start), int'(ph == 1 && prev_ph != 1));
      if (ph != prev_ph) begin
        if (prev_ph == 1) begin
          exp_w = hi_expect(reuse_this, ton_start, target);
          chk(run == exp_w, reuse_this ? "R6 repeated width" :
              (target == 0 ? "R7 saturated width" : "R2 measured width"), run, exp_w);
          chk(int'(ton_q) == exp_w, reuse_this ? "R6 ton kept" :
              (target == 0 ? "R7 ton max" : "R2 ton latched"), int'(ton_q), exp_w);
          chk(ph == 0, "R1 gap after hi", ph, 0);
          last_hi   = run;
          last_cond = 1;
          dead_ok   = 1;
          hi_done++;
        end else if (prev_ph == 2) begin
          chk(run == last_hi, "R3 lo equals hi", run, last_hi);
          chk(ph == 0, "R1 gap after lo", ph, 0);
          last_cond = 2;
          dead_ok   = 1;
        end else begin
          if (dead_ok) chk(run == gap_len(dead_rec), "R4 gap width", run, gap_len(dead_rec));
          chk(ph == ((last_cond == 1) ? 2 : 1), "R1 order", ph, (last_cond == 1) ? 2 : 1);
        end
        run = 0;
        if (ph == 0) begin
          dead_rec = int'(dt_cfg);
          target   = pick_t();
        end
        if (ph == 1) begin
          ton_start  = int'(ton_q);
          reuse_this = force_trip;
          dt_cfg     = rand_mode ? 6'($urandom % 64) : 6'(dt_fixed);
        end
      end
      run++;
      if (ph == 0 && run == 2 && mid_swap) dt_cfg = 6'($urandom % 64);
      cmp_trip = force_trip ? 1'b1 : (ph == 1 && target != 0 && run == target);
      prev_ph  = ph;
    end
  end

  task automatic wait_hi(input int n);
    int goal;
    goal = hi_done + n;
    while (hi_done < goal) @(posedge clk);
    #2;
  endtask

  task automatic wait_for_hi();
    do begin @(posedge clk); #2; end while (!drv_hi);
  endtask

  task automatic wait_for_lo();
    do begin @(posedge clk); #2; end while (!drv_lo);
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2417));
    rst_n = 1'b0;
    en    = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(!drv_hi && !drv_lo, "R8 reset outputs", int'(drv_hi | drv_lo), 0);
    chk(!hi_start, "R9 no marker in reset", int'(hi_start), 0);
    chk(ton_q == 12'd10, "R8 reset ton", int'(ton_q), 10);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    en = 1'b1;

    // Measured widths with a fixed gap.
    fixed_t = 8; dt_fixed = 3;
    wait_hi(3);
    // Zero gap setting behaves as one cycle.
    dt_fixed = 0;
    wait_hi(2);
    // Gap setting changed inside a gap must not alter that gap.
    dt_fixed = 5; mid_swap = 1;
    wait_hi(3);
    mid_swap = 0;
    // Comparator stuck high: last valid on-time is repeated.
    force_trip = 1;
    wait_hi(3);
    force_trip = 0; fixed_t = 13;
    wait_hi(2);
    // No trip: saturation at the counter maximum.
    fixed_t = 0;
    wait_hi(2);
    fixed_t = 5;
    wait_hi(2);

    // Enable drop in an upper interval.
    wait_for_hi();
    en = 1'b0;
    #1;
    chk(!drv_hi && !drv_lo, "R8 enable off outputs", int'(drv_hi | drv_lo), 0);
    @(posedge clk); #2;
    chk(ton_q == 12'd10, "R8 enable off ton", int'(ton_q), 10);
    en = 1'b1;
    // Repeat right after restart uses the default on-time.
    force_trip = 1;
    wait_hi(1);
    force_trip = 0; fixed_t = 9;
    wait_hi(2);

    // Reset in a lower interval.
    wait_for_lo();
    rst_n = 1'b0;
    #1;
    chk(!drv_hi && !drv_lo, "R8 reset mid-run outputs", int'(drv_hi | drv_lo), 0);
    chk(ton_q == 12'd10, "R8 reset mid-run ton", int'(ton_q), 10);
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;

    // Random widths and gap settings.
    rand_mode = 1;
    wait_hi(40);
    force_trip = 1;
    wait_hi(2);
    force_trip = 0;
    wait_hi(10);
    rand_mode = 0;
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule